// File: doc/BRIEF.md
# UART register bank with transmit queue and interrupts

This block is the software-visible register file of a small serial port. A 32-bit bus reaches it by byte address. Bits [1:0] of that address are dropped, so each register takes one word slot. The block holds a four-source interrupt unit with enable masks, a control word, a status word, a queue-control word and a queue-level readout. It also owns the storage of the transmit queue. A bus write to the transmit slot appends a byte. A one-cycle pop strobe from the serializer removes the oldest byte, which is always presented on `tx_byte`.

The receive side keeps only a single byte. The deserializer strobes `rx_valid` with a byte. The block latches it, clears its receive idle/empty flags and may raise a receive-threshold interrupt. A bus read of the receive slot marks the byte as consumed. The three slots at the top of the map are placeholders: they read as zero and ignore writes.

Top module: `uart_csr_bank`

## Requirements
- R1: The word index is `reg_addr[ADDR_W-1:2]`, with this order: 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 control, 4 status, 5 receive data, 6 transmit data, 7 queue control, 8 queue level, 9 to 11 placeholders. The control word reads back as written. Reads of the test slot, the transmit slot and the placeholders return zero. Writes to status, receive data, queue level and the placeholders change nothing.
- R2: Interrupt bits are numbered 0 transmit-threshold, 1 receive-threshold, 2 transmit-drained and 3 receive-overflow. Each interrupt pin is high exactly when its state bit and its enable bit are both set.
- R3: A write to the state slot clears every state bit written as 1. A write to the test slot sets every state bit written as 1.
- R4: A transmit-slot write appends `reg_wdata[7:0]` unless the queue holds DEPTH bytes, in which case the byte is dropped. Bytes leave in arrival order, and `tx_byte` shows the oldest one.
- R5: Status bit 0 (queue full) is set exactly when the level equals DEPTH. Status bit 2 (queue empty) is set exactly when the level is zero.
- R6: The transmit threshold is queue-control bits [7:5]. An accepted append that leaves the level at or above it sets state bit 0. A pop that leaves the level below it clears state bit 0.
- R7: A pop that empties the queue sets state bit 2.
- R8: Writing queue control with bit 1 set empties the queue at once. The queue-level slot reports the byte count in its low bits.
- R9: With control bit 1 (receive enable) set, `rx_valid` stores `rx_byte` in the receive-data slot and clears status bits 4 (receive idle) and 5 (receive empty). A read of the receive-data slot sets both bits again. With control bit 1 clear, `rx_valid` is ignored.
- R10: A received byte sets state bit 1 when the receive threshold in queue-control bits [4:2] is zero.
- R11: After reset every register is zero, except status, which reads 0x34.
- R12: A pop strobe is ignored while control bit 0 (transmit enable) is clear or while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Bus write strobe |
| reg_re | input | 1 | Bus read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_re` |
| tx_pop | input | 1 | Serializer took the head byte |
| tx_byte | output | 8 | Oldest queued byte |
| tx_ready | output | 1 | Queue not empty |
| rx_valid | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_enable | output | 1 | Control bit 0 |
| rx_enable | output | 1 | Control bit 1 |
| irq_tx_watermark | output | 1 | Transmit-threshold interrupt |
| irq_rx_watermark | output | 1 | Receive-threshold interrupt |
| irq_tx_empty | output | 1 | Transmit-drained interrupt |
| irq_rx_overflow | output | 1 | Receive-overflow interrupt |

## Verification
The bench builds the block with DEPTH=8 and ADDR_W=6. That queue depth can be filled and emptied in a few dozen cycles. The 3-bit threshold can be placed in the middle of the level range, so the transmit-threshold bit is seen both rising on appends and falling on pops. A dropped append at full capacity, strict arrival order across a pointer wrap and the drain-to-empty interrupt all occur within one short run.

// File: rtl/uart_csr_bank.sv
module uart_csr_bank #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              irq_tx_watermark,
  output logic              irq_rx_watermark,
  output logic              irq_tx_empty,
  output logic              irq_rx_overflow
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [IDX_W-1:0] idx;
  logic [3:0]       istate, ienable, istate_d;
  logic [31:0]      ctrl;
  logic [7:0]       qctrl;
  logic [7:0]       rx_q;
  logic             rx_idle, rx_empty;
  logic [LVL_W-1:0] level, level_d;
  logic [PTR_W-1:0] wptr, rptr;
  logic [7:0]       mem [DEPTH];

  assign idx = reg_addr[ADDR_W-1:2];

  logic wr_ist, wr_ien, wr_itest, wr_ctrl, wr_data, wr_qctrl, rd_rx;
  assign wr_ist   = reg_we && idx == IDX_W'(0);
  assign wr_ien   = reg_we && idx == IDX_W'(1);
  assign wr_itest = reg_we && idx == IDX_W'(2);
  assign wr_ctrl  = reg_we && idx == IDX_W'(3);
  assign wr_data  = reg_we && idx == IDX_W'(6);
  assign wr_qctrl = reg_we && idx == IDX_W'(7);
  assign rd_rx    = reg_re && idx == IDX_W'(5) && ctrl[1];

  logic full, push_ok, pop_ok, qrst, rx_acc;
  assign full    = level == FULL_LVL;
  assign push_ok = wr_data && !full;
  assign qrst    = wr_qctrl && reg_wdata[1];
  assign pop_ok  = tx_pop && ctrl[0] && level != '0 && !qrst;
  assign rx_acc  = rx_valid && ctrl[1];

  logic [31:0] lvl_next32, tx_thr, rx_thr;
  assign level_d    = qrst ? '0 : level + LVL_W'(push_ok) - LVL_W'(pop_ok);
  assign lvl_next32 = 32'(level_d);
  assign tx_thr     = 32'(qctrl[7:5]);
  assign rx_thr     = 32'(qctrl[4:2]);

  always_comb begin
    istate_d = istate;
    if (wr_ist) istate_d = istate_d & ~reg_wdata[3:0];
    if (pop_ok && lvl_next32 < tx_thr) istate_d[0] = 1'b0;
    if (push_ok && lvl_next32 >= tx_thr) istate_d[0] = 1'b1;
    if (pop_ok && level_d == '0) istate_d[2] = 1'b1;
    if (rx_acc && 32'd1 > rx_thr) istate_d[1] = 1'b1;
    if (wr_itest) istate_d = istate_d | reg_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istate   <= '0;
      ienable  <= '0;
      ctrl     <= '0;
      qctrl    <= '0;
      rx_q     <= '0;
      rx_idle  <= 1'b1;
      rx_empty <= 1'b1;
      level    <= '0;
      wptr     <= '0;
      rptr     <= '0;
    end else begin
      istate <= istate_d;
      level  <= level_d;
      if (wr_ien)   ienable <= reg_wdata[3:0];
      if (wr_ctrl)  ctrl    <= reg_wdata;
      if (wr_qctrl) qctrl   <= reg_wdata[7:0];
      if (qrst) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
      if (rx_acc) begin
        rx_q     <= rx_byte;
        rx_idle  <= 1'b0;
        rx_empty <= 1'b0;
      end else if (rd_rx) begin
        rx_idle  <= 1'b1;
        rx_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= reg_wdata[7:0];
  end

  logic [31:0] status;
  assign status = {26'd0, rx_empty, rx_idle, 1'b0, level == '0, 1'b0, full};

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      case (idx)
        IDX_W'(0): reg_rdata = {28'd0, istate};
        IDX_W'(1): reg_rdata = {28'd0, ienable};
        IDX_W'(3): reg_rdata = ctrl;
        IDX_W'(4): reg_rdata = status;
        IDX_W'(5): reg_rdata = {24'd0, rx_q};
        IDX_W'(7): reg_rdata = {24'd0, qctrl};
        IDX_W'(8): reg_rdata = 32'(level);
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign tx_byte          = mem[rptr];
  assign tx_ready         = level != '0;
  assign tx_enable        = ctrl[0];
  assign rx_enable        = ctrl[1];
  assign irq_tx_watermark = istate[0] & ienable[0];
  assign irq_rx_watermark = istate[1] & ienable[1];
  assign irq_tx_empty     = istate[2] & ienable[2];
  assign irq_rx_overflow  = istate[3] & ienable[3];

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && full && !tx_pop) |=> level == FULL_LVL);

  assert_drain_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && ctrl[0] && !qrst && level == LVL_W'(1)) |=> istate[2]);

  assert_test_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_itest |=> ((istate & $past(reg_wdata[3:0])) == $past(reg_wdata[3:0])));

  assert_rx_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ctrl[1]) |=> (!rx_idle && !rx_empty));

  assert_pop_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !reg_we) |=> $stable(level));
endmodule

// File: tb/uart_csr_bank_bench.sv
`timescale 1ns/100ps
module uart_csr_bank_bench;
  localparam int DEPTH = 8;
  localparam int ADDR_W = 6;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0, tx_pop = 0, rx_valid = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] tx_byte, rx_byte = '0;
  logic tx_ready, tx_enable, rx_enable;
  logic irq_txw, irq_rxw, irq_txe, irq_rxo;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uart_csr_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_uart_csr_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_enable(tx_enable),
    .rx_enable(rx_enable), .irq_tx_watermark(irq_txw),
    .irq_rx_watermark(irq_rxw), .irq_tx_empty(irq_txe),
    .irq_rx_overflow(irq_rxo));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(string tag, int act, int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = ADDR_W'(idx * 4); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(int idx, int exp, string tag);
    @(negedge clk);
    reg_re = 1; reg_addr = ADDR_W'(idx * 4);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    reg_re = 0;
  endtask

  task automatic pop();
    @(negedge clk); tx_pop = 1;
    @(posedge clk); #1; tx_pop = 0;
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(posedge clk); #1; rx_valid = 0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (reg_re) begin
        if (exp_q.size() == 0) eq("scoreboard underflow", 1, 0);
        else eq(tag_q.pop_front(), int'(reg_rdata), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    eq("watchdog expired", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(4, 32'h34, "R11 status reset");
    rd(0, 0, "R11 istate reset");
    rd(3, 0, "R11 ctrl reset");
    rd(8, 0, "R11 level reset");
    eq("R11 pins reset", {irq_txw, irq_rxw, irq_txe, irq_rxo}, 0);
    // R1 map
    wr(3, 32'hABCD0003);
    rd(3, 32'hABCD0003, "R1 ctrl readback");
    eq("R1 enables", {tx_enable, rx_enable}, 3);
    wr(4, 32'hFF); wr(5, 32'hFF); wr(8, 32'hFF);
    rd(4, 32'h34, "R1 status write ignored");
    rd(8, 0, "R1 level write ignored");
    rd(5, 0, "R1 rdata write ignored");
    wr(9, 32'h1234); wr(11, 32'h55);
    rd(9, 0, "R1 placeholder 9");
    rd(10, 0, "R1 placeholder 10");
    rd(11, 0, "R1 placeholder 11");
    rd(6, 0, "R1 wdata reads zero");
    // R2 and R3
    wr(2, 32'hF);
    rd(2, 0, "R1 test reads zero");
    rd(0, 32'hF, "R3 test sets state");
    eq("R2 pins masked", {irq_txw, irq_rxw, irq_txe, irq_rxo}, 0);
    wr(1, 32'h5);
    eq("R2 pins enable 0x5", {irq_rxo, irq_txe, irq_rxw, irq_txw}, 4'b0101);
    wr(0, 32'h1);
    rd(0, 32'hE, "R3 w1c one bit");
    eq("R2 tx_wm pin after clear", irq_txw, 0);
    wr(0, 32'hE);
    rd(0, 0, "R3 w1c rest");
    wr(1, 32'hF);
    // R4 R5 R6 fill
    wr(7, 32'h60);
    wr(6, 32'h11); wr(6, 32'h22);
    rd(4, 32'h30, "R5 not empty");
    eq("R6 below threshold", irq_txw, 0);
    wr(6, 32'h33);
    eq("R6 at threshold", irq_txw, 1);
    for (int k = 4; k <= 8; k++) wr(6, 32'h11 * k);
    rd(4, 32'h31, "R5 full");
    wr(6, 32'h99);
    rd(8, 8, "R4 full drop level");
    eq("R4 head byte", tx_byte, 8'h11);
    wr(0, 32'hF);
    // R12 pop gated
    wr(3, 32'h2);
    pop();
    rd(8, 8, "R12 pop with tx disabled");
    eq("R12 head unchanged", tx_byte, 8'h11);
    wr(3, 32'h3);
    pop();
    eq("R4 order after first pop", tx_byte, 8'h22);
    rd(4, 32'h30, "R5 full clears on pop");
    wr(2, 32'h1);
    for (int k = 1; k <= 7; k++) begin
      eq("R4 order", tx_byte, 8'h11 * (k + 1));
      pop();
      eq("R6 watermark on pop", irq_txw, (7 - k) >= 3 ? 1 : 0);
    end
    eq("R7 drain interrupt", irq_txe, 1);
    rd(4, 32'h34, "R5 empty after drain");
    pop();
    rd(8, 0, "R12 pop on empty ignored");
    // R8 queue reset
    wr(6, 1); wr(6, 2); wr(6, 3);
    rd(8, 3, "R8 level readout");
    wr(7, 32'h62);
    rd(8, 0, "R8 reset level");
    rd(4, 32'h34, "R8 status after reset");
    wr(6, 32'h5A);
    eq("R8 head after reset", tx_byte, 8'h5A);
    // R9 R10 receive
    wr(0, 32'hF);
    wr(7, 32'h60);
    rx(8'hC3);
    rd(4, 32'h00, "R9 rx flags clear");
    rd(0, 32'h2, "R10 rx watermark set");
    eq("R10 rx pin", irq_rxw, 1);
    rd(5, 32'hC3, "R9 rdata");
    rd(4, 32'h30, "R9 read restores flags");
    wr(7, 32'h64);
    wr(0, 32'hF);
    rx(8'h3C);
    rd(0, 0, "R10 threshold one no irq");
    rd(5, 32'h3C, "R9 rdata second");
    wr(3, 32'h1);
    rx(8'h77);
    rd(4, 32'h30, "R9 rx disabled flags");
    rd(5, 32'h3C, "R9 rx disabled data");
    // R2 overflow pin
    wr(2, 32'h8);
    eq("R2 overflow pin", irq_rxo, 1);
    rd(0, 32'h8, "R3 test bit 3");
    repeat (3) @(negedge clk);
    eq("scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule